// File: doc/BRIEF.md
# Secondary Issue Slot Gating Control

This block decides whether the second execution pipeline of a dual-issue core may receive instructions. It also runs the handshake with a power-domain sequencer that gates that pipeline off and brings it back. Software owns one enable bit. Clearing the bit stops issue to the secondary slot at once, so the pairing logic sends only no-operations there. The block then waits for every stage of the secondary pipeline to empty, and only after that does it ask the sequencer to remove power.

Setting the bit again asks the sequencer to restore power. Dual issue reopens only after the sequencer reports that power-up has finished. A change of the bit in the middle of a sequence never cuts that sequence short. The running power-down or power-up completes first, and the controller then heads straight for the state the bit now asks for.

Top module: `slot_gate_ctrl`

## Requirements
- R1: After reset, with the enable bit held at 1, issueEn is 1 and neither pwrDownReq nor pwrUpReq is asserted.
- R2: issueEn falls in the same cycle in which the enable bit is seen at 0, with no clock edge in between.
- R3: pwrDownReq is never raised while any bit of stageValid is 1. It rises at the first clock edge that samples stageValid equal to 0 after the controller has begun draining.
- R4: Once raised, pwrDownReq stays high until the edge that samples pwrDownDone at 1, and it falls at that edge.
- R5: With power off and the enable bit at 1, pwrUpReq rises at the next clock edge. It stays high until the edge that samples pwrUpDone at 1, and it falls at that edge.
- R6: issueEn stays 0 from the clearing of the bit until power-up completes. It is 0 whenever either request is high, and it returns to 1 at the edge that samples pwrUpDone, provided the bit is still 1.
- R7: If the bit is set again while the pipeline drains or while power-down runs, the power-down still completes. pwrUpReq then rises at the edge after the one that ended power-down.
- R8: If the bit is cleared while power-up runs, the power-up completes. issueEn stays 0, and a new drain and power-down follow.
- R9: pwrDownReq and pwrUpReq are never high together.
- R10: While the slot is enabled and powered, stageValid has no effect. No power-down request is raised, and issueEn stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotEnBit | input | 1 | Software enable bit for the secondary pipeline (1 = enable) |
| stageValid | input | NUM_STAGES (4) | Per-stage valid bits of the secondary pipeline |
| pwrDownDone | input | 1 | Sequencer reports that power-down has finished |
| pwrUpDone | input | 1 | Sequencer reports that power-up has finished |
| issueEn | output | 1 | Permits the pairing logic to issue into the secondary slot |
| pwrDownReq | output | 1 | Request to the sequencer to power the secondary pipeline down |
| pwrUpReq | output | 1 | Request to the sequencer to power the secondary pipeline up |

## Verification
Some properties are checked on every cycle:
- The two requests are mutually exclusive.
- A power-down request only ever rises after an empty pipeline was sampled.
- Each request is held until its matching done signal arrives.
- Issue is closed whenever a request is pending or the bit is clear.

Other behaviour can only be shown by the directed scenarios, because it depends on ordering across a whole sequence. This covers the exact edge at which each request rises and falls. It also covers the re-enable during a drain, which must still end in a full power-down followed by a power-up, and the disable during power-up, which must finish and then drain again.

// File: rtl/slot_gate_pkg.sv
package slot_gate_pkg;

  typedef enum logic [2:0] {
    ST_ON    = 3'd0,
    ST_DRAIN = 3'd1,
    ST_PDOWN = 3'd2,
    ST_OFF   = 3'd3,
    ST_PUP   = 3'd4
  } gateState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic issueOpen;
    logic downSet;
    logic downClr;
    logic upSet;
    logic upClr;
  } gateStrobe_t;

endpackage

// File: rtl/slot_gate_fsm.sv
module slot_gate_fsm
  import slot_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        slotEnBit,
  input  logic        pipeEmpty,
  input  logic        pwrDownDone,
  input  logic        pwrUpDone,
  output gateStrobe_t strb
);

  gateState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ON;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_ON: begin
        strb.issueOpen = slotEnBit;
        if (!slotEnBit) stateNxt = ST_DRAIN;
      end
      ST_DRAIN: begin
        // sequence runs to completion even if the bit returns
        if (pipeEmpty) begin
          strb.downSet = 1'b1;
          stateNxt     = ST_PDOWN;
        end
      end
      ST_PDOWN: begin
        if (pwrDownDone) begin
          strb.downClr = 1'b1;
          stateNxt     = ST_OFF;
        end
      end
      ST_OFF: begin
        if (slotEnBit) begin
          strb.upSet = 1'b1;
          stateNxt   = ST_PUP;
        end
      end
      ST_PUP: begin
        if (pwrUpDone) begin
          strb.upClr     = 1'b1;
          stateNxt       = ST_ON;
        end
      end
      default: stateNxt = ST_ON;
    endcase
  end

  AST_NO_OPEN_OFF_ON: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_ON) |-> !strb.issueOpen); // R6

endmodule

// File: rtl/slot_gate_dp.sv
module slot_gate_dp
  import slot_gate_pkg::*;
#(
  parameter int NUM_STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateStrobe_t           strb,
  input  logic [NUM_STAGES-1:0] stageValid,
  output logic                  pipeEmpty,
  output logic                  issueEn,
  output logic                  pwrDownReq,
  output logic                  pwrUpReq
);

  assign pipeEmpty = ~|stageValid;
  assign issueEn   = strb.issueOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrDownReq <= 1'b0;
      pwrUpReq   <= 1'b0;
    end else begin
      if (strb.downSet)      pwrDownReq <= 1'b1;
      else if (strb.downClr) pwrDownReq <= 1'b0;
      if (strb.upSet)        pwrUpReq   <= 1'b1;
      else if (strb.upClr)   pwrUpReq   <= 1'b0;
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pwrDownReq, pwrUpReq})); // R9

  AST_DOWN_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrDownReq) |-> ($past(stageValid) == '0)); // R3

endmodule

// File: rtl/slot_gate_ctrl.sv
module slot_gate_ctrl
  import slot_gate_pkg::*;
#(
  parameter int NUM_STAGES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  slotEnBit,
  input  logic [NUM_STAGES-1:0] stageValid,
  input  logic                  pwrDownDone,
  input  logic                  pwrUpDone,
  output logic                  issueEn,
  output logic                  pwrDownReq,
  output logic                  pwrUpReq
);

  gateStrobe_t strb;
  logic        pipeEmpty;

  slot_gate_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .slotEnBit  (slotEnBit),
    .pipeEmpty  (pipeEmpty),
    .pwrDownDone(pwrDownDone),
    .pwrUpDone  (pwrUpDone),
    .strb       (strb)
  );

  slot_gate_dp #(.NUM_STAGES(NUM_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .stageValid(stageValid),
    .pipeEmpty (pipeEmpty),
    .issueEn   (issueEn),
    .pwrDownReq(pwrDownReq),
    .pwrUpReq  (pwrUpReq)
  );

  AST_ISSUE_CUT: assert property (@(posedge clk) disable iff (!rstN)
    !slotEnBit |-> !issueEn); // R2

  AST_NO_ISSUE_IN_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDownReq || pwrUpReq) |-> !issueEn); // R6

  AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pwrDownReq && !pwrDownDone) |=> pwrDownReq); // R4

  AST_UP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pwrUpReq && !pwrUpDone) |=> pwrUpReq); // R5

endmodule

// File: tb/slot_gate_ctrl_bench.sv
`timescale 1ns/1ps
module slot_gate_ctrl_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       slotEnBit;
  logic [3:0] stageValid;
  logic       pwrDownDone;
  logic       pwrUpDone;
  logic       issueEn, pwrDownReq, pwrUpReq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  slot_gate_ctrl u_slot_gate_ctrl (
    .clk(clk), .rstN(rstN), .slotEnBit(slotEnBit), .stageValid(stageValid),
    .pwrDownDone(pwrDownDone), .pwrUpDone(pwrUpDone),
    .issueEn(issueEn), .pwrDownReq(pwrDownReq), .pwrUpReq(pwrUpReq)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // exp order: issueEn, pwrDownReq, pwrUpReq
  task automatic expect3(string req, logic eI, logic eD, logic eU);
    checks++;
    if (issueEn !== eI || pwrDownReq !== eD || pwrUpReq !== eU) begin
      fails++;
      $display("FAIL %s: issueEn/down/up actual %b%b%b expected %b%b%b",
               req, issueEn, pwrDownReq, pwrUpReq, eI, eD, eU);
    end
  endtask

  task automatic do_reset;
    rstN = 0; slotEnBit = 1; stageValid = 0; pwrDownDone = 0; pwrUpDone = 0;
    step(3);
    rstN = 1;
    step(1);
    expect3("R1", 1, 0, 0);
  endtask

  // clear bit, drain with busy pipeline, power down
  task automatic t_drain_down;
    stageValid = 4'b0110; slotEnBit = 0;
    #0.5; expect3("R2", 0, 0, 0);
    step(3); expect3("R3", 0, 0, 0);
    stageValid = 4'b1000;
    step(1); expect3("R3", 0, 0, 0);
    stageValid = 0;
    step(1); expect3("R3", 0, 1, 0);
    step(3); expect3("R4", 0, 1, 0);
    pwrDownDone = 1;
    step(1); pwrDownDone = 0; expect3("R4", 0, 0, 0);
    step(3); expect3("R6", 0, 0, 0);
  endtask

  task automatic t_power_up;
    slotEnBit = 1;
    step(1); expect3("R5", 0, 0, 1);
    step(2); expect3("R5", 0, 0, 1);
    pwrUpDone = 1;
    step(1); pwrUpDone = 0; expect3("R6", 1, 0, 0);
  endtask

  task automatic t_ignore_valid;
    stageValid = 4'b1111;
    step(3); expect3("R10", 1, 0, 0);
    stageValid = 0;
  endtask

  task automatic t_reenable_in_drain;
    stageValid = 4'b0001; slotEnBit = 0;
    step(1);
    slotEnBit = 1;
    step(2); expect3("R7", 0, 0, 0);
    stageValid = 0;
    step(1); expect3("R7", 0, 1, 0);
    pwrDownDone = 1;
    step(1); pwrDownDone = 0; expect3("R7", 0, 0, 0);
    step(1); expect3("R7", 0, 0, 1);
    pwrUpDone = 1;
    step(1); pwrUpDone = 0; expect3("R7", 1, 0, 0);
  endtask

  task automatic t_disable_in_up;
    slotEnBit = 0;
    step(2); expect3("R3", 0, 1, 0);
    pwrDownDone = 1; step(1); pwrDownDone = 0;
    slotEnBit = 1;
    step(1); expect3("R5", 0, 0, 1);
    slotEnBit = 0;
    step(1); expect3("R8", 0, 0, 1);
    pwrUpDone = 1;
    step(1); pwrUpDone = 0; expect3("R8", 0, 0, 0);
    step(1); expect3("R8", 0, 0, 0);
    step(1); expect3("R8", 0, 1, 0);
    pwrDownDone = 1; step(1); pwrDownDone = 0;
    slotEnBit = 1;
    step(1); expect3("R9", 0, 0, 1);
    pwrUpDone = 1; step(1); pwrUpDone = 0;
    expect3("R6", 1, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_drain_down();
    t_power_up();
    t_ignore_valid();
    t_reenable_in_drain();
    t_disable_in_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule